// File: doc/BRIEF.md
# Regional Clock Divider

This block turns one incoming clock into one outgoing clock. A parameter fixed at elaboration picks the variant: a straight wire from input to output, or a copy of the input divided by an integer from one to eight. In the divided variants two control inputs shape the output. An active-high enable stops and restarts the output clock without shortening any pulse. An active-high clear stops it at once, with no clock edge needed.

When the clear is released, the release first passes through a short synchronizer clocked by the input. Counting then restarts from the top of a period, so the first output period is a full one. Odd ratios use a high phase one input cycle longer than the low phase, which keeps every register on the rising edge. Divide-by-one is a separate variant from pass-through: the frequency stays the same, but the enable and clear still act. A ratio outside the legal set stops elaboration with an error.

Top module: `rclk_divider`

## Requirements
- R1: With DIVIDE = 0 (pass-through), clk_out equals clk_in at all times, and neither en nor clr changes it.
- R2: With DIVIDE = N from 2 to 8 and en held high, clk_out repeats every N rising edges of clk_in. It is high for (N+1)/2 of those cycles and low for the remaining N-(N+1)/2, and it changes only just after a rising edge of clk_in.
- R3: With DIVIDE = 1 and en high, clk_out reproduces each high phase of clk_in and is low while clk_in is low.
- R4: In every divided variant (DIVIDE from 1 to 8), clk_out is low while clr is high, and it goes low as soon as clr rises, even in the middle of a high phase and with no clk_in edge.
- R5: After clr falls, with SYNC_STAGES = 2 and en high, clk_out stays low through the first two rising edges of clk_in and goes high at the third. It then runs full-length high and low phases from there.
- R6: In divided variants, en is sampled on rising edges of clk_in. A high phase already under way always runs to its full length. After that, clk_out stays low for as long as en is low.
- R7: When en returns high, counting resumes from the held position. For N of 2 or more, the next rise of clk_out comes between 1 and N-(N+1)/2 rising edges later. For N = 1, it comes with the next high phase of clk_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Source clock |
| en | input | 1 | Output enable, active high, used in divided variants only |
| clr | input | 1 | Asynchronous clear, active high, used in divided variants only |
| clk_out | output | 1 | Pass-through or divided clock |

## Verification
The bench drives all nine variants side by side from the same clock, enable and clear. It looks for an odd ratio built with equal halves, which would give a high time one cycle short. It looks for an enable that cuts a high phase, which would leave a runt pulse, and for a resume that restarts the count instead of continuing it. It checks for a clear that waits for a clock edge, which would leave clk_out high in the middle of a period. It also checks for a clear release that is not synchronized, which would make the first pulse arrive early. Finally, it checks that the pass-through variant never reacts to en or clr.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  // DIVIDE value that selects straight pass-through.
  localparam int PASS_THROUGH = 0;
  localparam int MAX_RATIO    = 8;

  // Cycles spent high per output period (longer half for odd ratios).
  function automatic int high_cycles(int ratio);
    return (ratio + 1) / 2;
  endfunction

  function automatic bit divide_legal(int ratio);
    return (ratio >= PASS_THROUGH) && (ratio <= MAX_RATIO);
  endfunction
endpackage

// File: rtl/rcd_clr_sync.sv
// Clear is taken asynchronously; its release is retimed to clk_in.
module rcd_clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_in,
  input  logic clr,
  output logic hold
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk_in or posedge clr) begin
    if (clr) shreg <= '1;
    else     shreg <= shreg << 1;
  end

  assign hold = shreg[STAGES-1];
endmodule

// File: rtl/rcd_phase_counter.sv
// Ratio 2..8: position counter plus registered phase output.
module rcd_phase_counter #(
  parameter int DIV = 2
) (
  input  logic clk_in,
  input  logic clr,
  input  logic hold,
  input  logic en,
  output logic phase_hi
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST_POS = CW'(DIV - 1);
  localparam logic [CW-1:0] HI_LEN   = CW'(rcd_pkg::high_cycles(DIV));

  logic [CW-1:0] pos;
  logic [CW-1:0] pos_nxt;
  logic          out_q;

  assign pos_nxt = (pos == LAST_POS) ? '0 : pos + 1'b1;

  // Parked on the last position so the first advance starts a period.
  // A running high phase keeps counting even with en low.
  always_ff @(posedge clk_in or posedge clr) begin
    if (clr) begin
      pos   <= LAST_POS;
      out_q <= 1'b0;
    end else if (hold) begin
      pos   <= LAST_POS;
      out_q <= 1'b0;
    end else if (en || out_q) begin
      pos   <= pos_nxt;
      out_q <= (pos_nxt < HI_LEN);
    end
  end

  assign phase_hi = out_q;
endmodule

// File: rtl/rcd_pulse_gate.sv
// Ratio 1: whole input pulses gated by an enable retimed while clk_in is low.
module rcd_pulse_gate (
  input  logic clk_in,
  input  logic clr,
  input  logic hold,
  input  logic en,
  output logic clk_gated
);
  logic gate_q;

  always_ff @(negedge clk_in or posedge clr) begin
    if (clr) gate_q <= 1'b0;
    else     gate_q <= en && !hold;
  end

  assign clk_gated = clk_in & gate_q;
endmodule

// File: rtl/rclk_divider.sv
module rclk_divider #(
  parameter int DIVIDE      = rcd_pkg::PASS_THROUGH,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_in,
  input  logic en,
  input  logic clr,
  output logic clk_out
);
  if (!rcd_pkg::divide_legal(DIVIDE)) begin : g_bad_ratio
    $error("rclk_divider: DIVIDE must be 0 (pass-through) or 1..8");
  end else if (SYNC_STAGES < 1) begin : g_bad_sync
    $error("rclk_divider: SYNC_STAGES must be at least 1");
  end else if (DIVIDE == rcd_pkg::PASS_THROUGH) begin : g_pass
    logic unused_ctrl;
    assign unused_ctrl = en ^ clr;
    assign clk_out = clk_in;
  end else begin : g_div
    logic hold;

    rcd_clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_in (clk_in),
      .clr    (clr),
      .hold   (hold)
    );

    if (DIVIDE == 1) begin : g_unit
      rcd_pulse_gate u_gate (
        .clk_in    (clk_in),
        .clr       (clr),
        .hold      (hold),
        .en        (en),
        .clk_gated (clk_out)
      );
    end else begin : g_ratio
      rcd_phase_counter #(.DIV(DIVIDE)) u_cnt (
        .clk_in   (clk_in),
        .clr      (clr),
        .hold     (hold),
        .en       (en),
        .phase_hi (clk_out)
      );
    end
  end
endmodule

// File: rtl/rcd_checker.sv
module rcd_checker #(
  parameter int DIVIDE      = 0,
  parameter int SYNC_STAGES = 2
) (
  input logic clk_in,
  input logic en,
  input logic clr,
  input logic clk_out
);
  logic unused_chk;
  assign unused_chk = ^{en, clr, clk_out};

  if (DIVIDE >= 2) begin : g_ratio
    localparam int HI = rcd_pkg::high_cycles(DIVIDE);
    localparam int LO = DIVIDE - HI;

    logic [3:0] hi_run;
    logic [3:0] lo_run;
    logic [3:0] since_rel;
    logic       clean;

    always_ff @(posedge clk_in or posedge clr) begin
      if (clr) begin
        hi_run    <= 4'd0;
        lo_run    <= 4'd0;
        since_rel <= 4'd0;
        clean     <= 1'b0;
      end else begin
        hi_run <= clk_out ? hi_run + 4'd1 : 4'd0;
        lo_run <= clk_out ? 4'd0 : ((lo_run == 4'hF) ? lo_run : lo_run + 4'd1);
        if (clk_out)  clean <= 1'b1;
        else if (!en) clean <= 1'b0;
        if (since_rel != 4'hF) since_rel <= since_rel + 4'd1;
      end
    end

    AST_HIGH_RUN: assert property (@(posedge clk_in) disable iff (clr) $fell(clk_out) |-> hi_run == 4'(HI)); // R2
    AST_LOW_RUN: assert property (@(posedge clk_in) disable iff (clr) ($rose(clk_out) && clean) |-> lo_run == 4'(LO)); // R2
    AST_HOLD_LOW: assert property (@(posedge clk_in) disable iff (clr) (!en && !clk_out) |=> !clk_out); // R6
    AST_RELEASE_QUIET: assert property (@(posedge clk_in) disable iff (clr) (since_rel <= 4'(SYNC_STAGES)) |-> !clk_out); // R5
    AST_CLR_QUIET: assert property (@(posedge clk_in) clr |-> !clk_out); // R4
  end
endmodule

bind rclk_divider rcd_checker #(.DIVIDE(DIVIDE), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_in  (clk_in),
  .en      (en),
  .clr     (clr),
  .clk_out (clk_out)
);

// File: tb/tb_rclk_divider.sv
`timescale 1ns/100ps
module tb_rclk_divider;
  logic       clk = 1'b0;
  logic       en;
  logic       clr;
  logic [8:0] outs;

  int checks = 0;
  int fails  = 0;
  bit score_on = 1'b0;
  bit done = 1'b0;
  int exp_q [9][$];

  int  lvl   [9];
  int  run   [9];
  bit  armed [9];

  always #2 clk = ~clk;   // 250 MHz

  for (genvar k = 0; k < 9; k++) begin : g_ratio
    rclk_divider #(.DIVIDE(k)) dut (
      .clk_in  (clk),
      .en      (en),
      .clr     (clr),
      .clk_out (outs[k])
    );
  end

  function automatic int hi_of(int k);
    return (k + 1) / 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Driver side of the scoreboard: expected runs, high runs tagged +100.
  task automatic push_periods(int cycles);
    for (int k = 2; k < 9; k++) begin
      exp_q[k].delete();
      for (int p = 0; p < cycles / k; p++) begin
        exp_q[k].push_back(100 + hi_of(k));
        exp_q[k].push_back(k - hi_of(k));
      end
    end
  endtask

  // Monitor: measures run lengths of each divided output.
  always @(posedge clk) begin
    #0.5;
    for (int k = 2; k < 9; k++) begin
      if (clr) begin
        armed[k] = 1'b0;
        run[k]   = 0;
        lvl[k]   = 0;
      end else if (int'(outs[k]) == lvl[k]) begin
        run[k]++;
      end else begin
        if (armed[k]) begin
          if (lvl[k] == 1) begin
            if (score_on && exp_q[k].size() > 0) begin
              int e;
              e = exp_q[k].pop_front();
              chk(100 + run[k] == e, "R2 high run", 100 + run[k], e);
            end else if (!score_on) begin
              chk(run[k] == hi_of(k), "R6 full high phase", run[k], hi_of(k));
            end
          end else if (score_on && exp_q[k].size() > 0) begin
            int e;
            e = exp_q[k].pop_front();
            chk(run[k] == e, "R2 low run", run[k], e);
          end
        end else if (outs[k]) begin
          armed[k] = 1'b1;
        end
        lvl[k] = int'(outs[k]);
        run[k] = 1;
      end
    end
  end

  task automatic release_and_score(int cycles);
    push_periods(cycles);
    score_on = 1'b1;
    clr = 1'b0;
    tick();
    chk(outs[8:1] == 8'h00, "R5 low at edge 1", outs[8:1], 0);
    tick();
    chk(outs[8:1] == 8'h00, "R5 low at edge 2", outs[8:1], 0);
    tick();
    chk(outs[8:1] == 8'hFF, "R5 high at edge 3", outs[8:1], 255);
    for (int i = 0; i < cycles - 3; i++) begin
      tick();
      chk(outs[1] == 1'b1, "R3 unit ratio high phase", outs[1], 1);
      chk(outs[0] == 1'b1, "R1 pass-through", outs[0], 1);
    end
    score_on = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    en  = 1'b0;
    clr = 1'b1;
    repeat (3) tick();
    chk(outs[8:1] == 8'h00, "R4 outputs low under clear", outs[8:1], 0);
    chk(outs[0] == 1'b1, "R1 clear ignored", outs[0], 1);

    en = 1'b1;
    release_and_score(60);

    // R3: low phase of clk_in gives low output
    @(negedge clk);
    #0.5;
    chk(outs[1] == 1'b0, "R3 low while clk_in low", outs[1], 0);
    chk(outs[0] == 1'b0, "R1 follows low clk_in", outs[0], 0);
    tick();

    // R6: enable removal, then R7: resume
    begin
      bit late_hi [9];
      int first   [9];
      en = 1'b0;
      for (int i = 0; i < 20; i++) begin
        tick();
        for (int k = 1; k < 9; k++)
          if (outs[k] && (k == 1 || i >= k)) late_hi[k] = 1'b1;
        chk(outs[0] == 1'b1, "R1 enable ignored", outs[0], 1);
      end
      for (int k = 1; k < 9; k++)
        chk(!late_hi[k], "R6 held low while disabled", late_hi[k], 0);
      en = 1'b1;
      for (int i = 1; i <= 12; i++) begin
        tick();
        for (int k = 1; k < 9; k++)
          if (first[k] == 0 && outs[k]) first[k] = i;
      end
      chk(first[1] == 1, "R7 unit ratio resume", first[1], 1);
      for (int k = 2; k < 9; k++)
        chk(first[k] >= 1 && first[k] <= k - hi_of(k), "R7 resume from held count", first[k], k - hi_of(k));
    end

    // R4: clear in the middle of a high phase
    begin
      bit prev;
      int guard = 0;
      prev = outs[8];
      tick();
      while (!(!prev && outs[8]) && guard < 40) begin
        prev = outs[8];
        tick();
        guard++;
      end
      tick();
      chk(outs[8] == 1'b1, "R2 ratio 8 still high", outs[8], 1);
      #0.5 clr = 1'b1;
      #0.3;
      chk(outs[8:1] == 8'h00, "R4 immediate clear", outs[8:1], 0);
      chk(outs[0] == 1'b1, "R1 clear ignored mid-phase", outs[0], 1);
    end
    repeat (3) tick();
    release_and_score(40);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule